// File: doc/BRIEF.md
# Per-Queue Ordering Issue Filter

This block sits between a source of queue commands and the engines that carry out enqueue and dequeue operations on queues held in memory. Each command names a queue by its base address and carries an operation code. The filter holds pending commands in a small table and chooses, every cycle, at most one command that may go to an engine. Commands aimed at different queues pass each other freely. Commands aimed at the same queue leave in the order they arrived, and a later one waits until the earlier one has finished its pointer update, which the engine reports as a completion.

A fence command gives the only ordering across queues. It occupies a table slot and never reaches an engine. It retires once every command older than it has completed, and until then nothing younger may leave. When several commands are free to go in the same cycle, the oldest goes first. A full flag tells the command source to hold off while every slot is in use.

Top module: `qord_issue_filter`

## Requirements
- R1: While `rst` is high at a clock edge, the table empties, and after that edge `full` and `iss_valid` are both 0.
- R2: A command with `in_valid` high at an edge is stored in the lowest-numbered free slot when `full` was 0 before that edge; when `full` was 1 it is dropped and has no effect. `full` is 1 after an edge exactly when all DEPTH slots are occupied after that edge.
- R3: A non-fence command issues only when no older occupied command has the same base address, whether that older command is still waiting or has issued and not completed.
- R4: A command whose base address differs from every older occupied command, with no older fence, may issue while older commands for other queues are still blocked.
- R5: At most one command issues per edge, and of the commands eligible before an edge the oldest is the one that issues; `iss_slot` names the slot that holds it.
- R6: A command accepted at one edge can appear on the issue outputs no earlier than the following edge, and appears there at that edge when nothing blocks it and nothing older is eligible.
- R7: A fence blocks every younger command from issuing; it retires and frees its slot at the first edge at which no older occupied command remains, and it never appears on the issue outputs.
- R8: `cmp_valid` with `cmp_slot` naming an issued command frees that slot at the edge; a younger same-queue command can then issue at the next edge. A completion naming a slot that is free or still waiting is ignored.
- R9: `in_op` encodes enqueue as 2'b00, dequeue as 2'b01 and fence as any value with bit 1 set; on issue, `iss_op` and `iss_addr` carry the stored code and base address of the issued command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | New command present |
| in_op | input | 2 | Operation code of the new command |
| in_addr | input | AW | Queue base address of the new command |
| full | output | 1 | All slots occupied; source must hold its command |
| cmp_valid | input | 1 | An engine reports a finished command |
| cmp_slot | input | IW | Slot of the finished command |
| iss_valid | output | 1 | A command is issued this cycle |
| iss_slot | output | IW | Slot of the issued command |
| iss_op | output | 2 | Operation code of the issued command |
| iss_addr | output | AW | Queue base address of the issued command |

## Verification
The case that needs care is a completion arriving at the very edge where the table is full and the source presents a new command. The bench fills all slots with commands for one queue, then drives a completion for the single issued slot together with a new command for another queue: the slot is freed, yet the new command must be dropped because the full flag seen before the edge was high. The reference model judges this by showing the freed slot, the falling full flag, and exactly one later issue for that queue once the command is presented again; a completion for a still-waiting slot is also driven while full and must change nothing.

// File: rtl/qord_pkg.sv
package qord_pkg;

  typedef enum logic [1:0] {
    SLOT_FREE = 2'd0,
    SLOT_WAIT = 2'd1,
    SLOT_BUSY = 2'd2
  } slot_st_e;

  localparam logic [1:0] OPC_ENQ   = 2'b00;
  localparam logic [1:0] OPC_DEQ   = 2'b01;
  localparam logic [1:0] OPC_FENCE = 2'b10;

  // any code with bit 1 set orders across queues
  function automatic logic op_is_fence(input logic [1:0] op);
    return op[1];
  endfunction

endpackage

// File: rtl/qord_age_mtx.sv
// Relative age of slots: older[r][c] is set when slot c entered before slot r.
module qord_age_mtx #(
  parameter int DEPTH = 8,
  parameter int IW    = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         alloc_en,
  input  logic [IW-1:0]                alloc_idx,
  input  logic [DEPTH-1:0]             occ,
  output logic [DEPTH-1:0][DEPTH-1:0]  older
);

  always_ff @(posedge clk) begin
    if (rst) begin
      older <= '0;
    end else if (alloc_en) begin
      for (int r = 0; r < DEPTH; r++) begin
        if (IW'(r) == alloc_idx) older[r] <= occ;
        else                     older[r][alloc_idx] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/qord_elig.sv
// Per-slot eligibility: waiting and not held back by any older occupied slot.
module qord_elig #(
  parameter int DEPTH = 8,
  parameter int AW    = 32
) (
  input  logic [DEPTH-1:0]             occ,
  input  logic [DEPTH-1:0]             wait_m,
  input  logic [DEPTH-1:0]             fence_m,
  input  logic [DEPTH-1:0][AW-1:0]     addr,
  input  logic [DEPTH-1:0][DEPTH-1:0]  older,
  output logic [DEPTH-1:0]             elig
);

  for (genvar i = 0; i < DEPTH; i++) begin : g_row
    logic blocked;
    always_comb begin
      blocked = 1'b0;
      for (int j = 0; j < DEPTH; j++) begin
        if (occ[j] && older[i][j] &&
            (fence_m[i] || fence_m[j] || (addr[j] == addr[i])))
          blocked = 1'b1;
      end
    end
    assign elig[i] = wait_m[i] & ~blocked;
  end

endmodule

// File: rtl/qord_pick.sv
// Oldest-first choice among eligible slots.
module qord_pick #(
  parameter int DEPTH = 8,
  parameter int IW    = 3
) (
  input  logic [DEPTH-1:0]             elig,
  input  logic [DEPTH-1:0][DEPTH-1:0]  older,
  output logic                         win_any,
  output logic [IW-1:0]                win_idx
);

  logic [DEPTH-1:0] win;

  for (genvar i = 0; i < DEPTH; i++) begin : g_win
    assign win[i] = elig[i] & ~(|(elig & older[i]));
  end

  always_comb begin
    win_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (win[i]) win_idx = IW'(i);
    end
  end

  assign win_any = |win;

endmodule

// File: rtl/qord_issue_filter.sv
module qord_issue_filter
  import qord_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [1:0]    in_op,
  input  logic [AW-1:0] in_addr,
  output logic          full,
  input  logic          cmp_valid,
  input  logic [IW-1:0] cmp_slot,
  output logic          iss_valid,
  output logic [IW-1:0] iss_slot,
  output logic [1:0]    iss_op,
  output logic [AW-1:0] iss_addr
);

  slot_st_e                  st_q [DEPTH];
  logic [DEPTH-1:0][AW-1:0]  addr_q;
  logic [DEPTH-1:0][1:0]     op_q;

  logic [DEPTH-1:0] occ, wait_m, busy_m, fence_m, occ_nxt, elig;
  logic [DEPTH-1:0][DEPTH-1:0] older_m;

  for (genvar i = 0; i < DEPTH; i++) begin : g_flags
    assign occ[i]     = (st_q[i] != SLOT_FREE);
    assign wait_m[i]  = (st_q[i] == SLOT_WAIT);
    assign busy_m[i]  = (st_q[i] == SLOT_BUSY);
    assign fence_m[i] = op_is_fence(op_q[i]);
  end

  // lowest free slot
  logic          free_any;
  logic [IW-1:0] free_idx;
  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!occ[i]) begin
        free_any = 1'b1;
        free_idx = IW'(i);
      end
    end
  end

  logic accept, cmp_hit, win_any, win_fence;
  logic [IW-1:0] win_idx;

  assign accept    = in_valid & ~full & free_any;
  assign cmp_hit   = cmp_valid & busy_m[cmp_slot];
  assign win_fence = fence_m[win_idx];

  qord_age_mtx #(.DEPTH(DEPTH), .IW(IW)) u_age (
    .clk(clk), .rst(rst), .alloc_en(accept), .alloc_idx(free_idx),
    .occ(occ), .older(older_m)
  );

  qord_elig #(.DEPTH(DEPTH), .AW(AW)) u_elig (
    .occ(occ), .wait_m(wait_m), .fence_m(fence_m), .addr(addr_q),
    .older(older_m), .elig(elig)
  );

  qord_pick #(.DEPTH(DEPTH), .IW(IW)) u_pick (
    .elig(elig), .older(older_m), .win_any(win_any), .win_idx(win_idx)
  );

  always_comb begin
    occ_nxt = occ;
    if (cmp_hit)               occ_nxt[cmp_slot] = 1'b0;
    if (win_any && win_fence)  occ_nxt[win_idx]  = 1'b0;
    if (accept)                occ_nxt[free_idx] = 1'b1;
  end

  // payload storage, no reset
  always_ff @(posedge clk) begin
    if (accept) begin
      addr_q[free_idx] <= in_addr;
      op_q[free_idx]   <= in_op;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) st_q[i] <= SLOT_FREE;
      iss_valid <= 1'b0;
      iss_slot  <= '0;
      iss_op    <= '0;
      iss_addr  <= '0;
      full      <= 1'b0;
    end else begin
      iss_valid <= 1'b0;
      if (accept)  st_q[free_idx] <= SLOT_WAIT;
      if (cmp_hit) st_q[cmp_slot] <= SLOT_FREE;
      if (win_any) begin
        if (win_fence) begin
          st_q[win_idx] <= SLOT_FREE;
        end else begin
          st_q[win_idx] <= SLOT_BUSY;
          iss_valid     <= 1'b1;
          iss_slot      <= win_idx;
          iss_op        <= op_q[win_idx];
          iss_addr      <= addr_q[win_idx];
        end
      end
      full <= &occ_nxt;
    end
  end

endmodule

// File: rtl/qord_issue_filter_chk.sv
module qord_issue_filter_chk #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int IW    = 3
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         in_valid,
  input logic                         full,
  input logic                         iss_valid,
  input logic [IW-1:0]                iss_slot,
  input logic [1:0]                   iss_op,
  input logic [AW-1:0]                iss_addr,
  input logic [DEPTH-1:0]             occ,
  input logic [DEPTH-1:0]             busy_m,
  input logic [DEPTH-1:0]             fence_m,
  input logic [DEPTH-1:0][DEPTH-1:0]  older_m,
  input logic [DEPTH-1:0][AW-1:0]     addr_q
);

  function automatic logic older_same_queue(input logic [IW-1:0] s);
    logic r = 1'b0;
    for (int j = 0; j < DEPTH; j++)
      if (occ[j] && older_m[s][j] && !fence_m[j] && addr_q[j] == iss_addr) r = 1'b1;
    return r;
  endfunction

  function automatic logic older_fence(input logic [IW-1:0] s);
    logic r = 1'b0;
    for (int j = 0; j < DEPTH; j++)
      if (occ[j] && older_m[s][j] && fence_m[j]) r = 1'b1;
    return r;
  endfunction

  p_full_occ_r2: assert property (@(posedge clk) disable iff (rst)
    full == (&occ));

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
    (full && in_valid) |=> ($countones(occ) <= $past($countones(occ))));

  p_same_queue_order_r3: assert property (@(posedge clk) disable iff (rst)
    iss_valid |-> !older_same_queue(iss_slot));

  p_fence_block_r7: assert property (@(posedge clk) disable iff (rst)
    iss_valid |-> !older_fence(iss_slot));

  p_issue_busy_r5: assert property (@(posedge clk) disable iff (rst)
    iss_valid |-> busy_m[iss_slot]);

  p_no_fence_issue_r9: assert property (@(posedge clk) disable iff (rst)
    iss_valid |-> !iss_op[1]);

endmodule

bind qord_issue_filter qord_issue_filter_chk #(.DEPTH(DEPTH), .AW(AW), .IW(IW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .full(full),
  .iss_valid(iss_valid), .iss_slot(iss_slot), .iss_op(iss_op), .iss_addr(iss_addr),
  .occ(occ), .busy_m(busy_m), .fence_m(fence_m), .older_m(older_m), .addr_q(addr_q)
);

// File: tb/qord_issue_filter_test.sv
`timescale 1ns/1ps
module qord_issue_filter_test;

  localparam int DEPTH = 8;
  localparam int AW    = 32;
  localparam int IW    = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [1:0]    in_op = 2'b00;
  logic [AW-1:0] in_addr = '0;
  logic          cmp_valid = 1'b0;
  logic [IW-1:0] cmp_slot = '0;
  logic          full, iss_valid;
  logic [IW-1:0] iss_slot;
  logic [1:0]    iss_op;
  logic [AW-1:0] iss_addr;

  always #10 clk = ~clk;

  qord_issue_filter #(.DEPTH(DEPTH), .AW(AW)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_addr(in_addr),
    .full(full), .cmp_valid(cmp_valid), .cmp_slot(cmp_slot),
    .iss_valid(iss_valid), .iss_slot(iss_slot), .iss_op(iss_op), .iss_addr(iss_addr)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model: 0 free, 1 waiting, 2 issued
  int            m_st  [DEPTH];
  int            m_seq [DEPTH];
  logic [AW-1:0] m_addr[DEPTH];
  logic [1:0]    m_op  [DEPTH];
  int            seqctr = 0;
  logic          e_iss = 0, e_full = 0;
  int            e_slot = 0;
  logic [AW-1:0] e_addr = '0;
  logic [1:0]    e_op = '0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    int win, fr;
    bit hit, acc, blk, all;
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) m_st[i] = 0;
      e_iss = 0; e_full = 0;
      return;
    end
    win = -1;
    for (int i = 0; i < DEPTH; i++) begin
      if (m_st[i] == 1) begin
        blk = 0;
        for (int j = 0; j < DEPTH; j++)
          if (j != i && m_st[j] != 0 && m_seq[j] < m_seq[i] &&
              (m_op[i][1] || m_op[j][1] || m_addr[j] == m_addr[i])) blk = 1;
        if (!blk && (win < 0 || m_seq[i] < m_seq[win])) win = i;
      end
    end
    hit = cmp_valid && m_st[cmp_slot] == 2;
    fr = -1;
    for (int i = 0; i < DEPTH; i++) if (m_st[i] == 0 && fr < 0) fr = i;
    acc = in_valid && !e_full && fr >= 0;
    e_iss = 0;
    if (hit) m_st[cmp_slot] = 0;
    if (win >= 0) begin
      if (m_op[win][1]) m_st[win] = 0;
      else begin
        m_st[win] = 2; e_iss = 1; e_slot = win; e_addr = m_addr[win]; e_op = m_op[win];
      end
    end
    if (acc) begin
      m_st[fr] = 1; m_addr[fr] = in_addr; m_op[fr] = in_op; m_seq[fr] = seqctr; seqctr++;
    end
    all = 1;
    for (int i = 0; i < DEPTH; i++) if (m_st[i] == 0) all = 0;
    e_full = all;
  endtask

  task automatic compare();
    chk(iss_valid === e_iss, "R5 iss_valid", 64'(iss_valid), 64'(e_iss));
    chk(full === e_full, "R2 full", 64'(full), 64'(e_full));
    if (e_iss && iss_valid) begin
      chk(iss_slot == IW'(e_slot), "R5 iss_slot", 64'(iss_slot), 64'(e_slot));
      chk(iss_addr === e_addr, "R9 iss_addr", 64'(iss_addr), 64'(e_addr));
      chk(iss_op === e_op, "R9 iss_op", 64'(iss_op), 64'(e_op));
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    #1;
    compare();
    @(negedge clk);
  endtask

  task automatic idle();
    in_valid = 0; cmp_valid = 0; tick();
  endtask

  task automatic push(input logic [1:0] op, input logic [AW-1:0] a);
    in_valid = 1; in_op = op; in_addr = a; cmp_valid = 0; tick(); in_valid = 0;
  endtask

  task automatic complete(input int s);
    in_valid = 0; cmp_valid = 1; cmp_slot = IW'(s); tick(); cmp_valid = 0;
  endtask

  task automatic push_cmp(input logic [1:0] op, input logic [AW-1:0] a, input int s);
    in_valid = 1; in_op = op; in_addr = a; cmp_valid = 1; cmp_slot = IW'(s);
    tick(); in_valid = 0; cmp_valid = 0;
  endtask

  task automatic exp_issue(input string tag, input int s, input logic [AW-1:0] a);
    chk(iss_valid === 1'b1, tag, 64'(iss_valid), 64'd1);
    chk(iss_slot == IW'(s) && iss_addr == a, tag, {29'd0, iss_slot, iss_addr}, {29'(0), IW'(s), a});
  endtask

  task automatic exp_none(input string tag);
    chk(iss_valid === 1'b0, tag, 64'(iss_valid), 64'd0);
  endtask

  initial begin
    @(negedge clk);
    rst = 1; tick(); tick(); tick();
    rst = 0;
    exp_none("R1 no issue after reset");
    chk(full === 1'b0, "R1 full after reset", 64'(full), 64'd0);

    // single enqueue: latency and fields
    push(2'b00, 32'h10);
    exp_none("R6 not same edge");
    idle();
    exp_issue("R6 first issue", 0, 32'h10);
    chk(iss_op === 2'b00, "R9 enqueue code", 64'(iss_op), 64'd0);

    // same queue waits for completion
    push(2'b01, 32'h10);
    idle(); exp_none("R3 held");
    idle(); exp_none("R3 held");
    complete(0); exp_none("R8 not before next edge");
    idle(); exp_issue("R8 successor issues", 1, 32'h10);
    chk(iss_op === 2'b01, "R9 dequeue code", 64'(iss_op), 64'd1);
    complete(1);

    // different queue overtakes a blocked one
    push(2'b00, 32'h20); idle();
    push(2'b00, 32'h20);
    push(2'b00, 32'h30); exp_none("R3 second same queue held");
    idle(); exp_issue("R4 bypass", 2, 32'h30);
    complete(0);
    idle(); exp_issue("R3 in order after completion", 1, 32'h20);
    complete(1); complete(2);

    // fence ordering and oldest first
    push(2'b00, 32'h40);
    push(2'b10, 32'h0);
    push(2'b00, 32'h50);
    push(2'b01, 32'h58);
    idle(); exp_none("R7 younger held by fence");
    idle(); exp_none("R7 younger held by fence");
    complete(0); exp_none("R7 fence still pending");
    idle(); exp_none("R7 fence retires silently");
    idle(); exp_issue("R5 oldest first", 2, 32'h50);
    idle(); exp_issue("R5 next oldest", 3, 32'h58);
    complete(2); complete(3);

    // fill, ignored inputs, completion at the full edge
    for (int k = 0; k < DEPTH; k++) push(2'b00, 32'h60);
    chk(full === 1'b1, "R2 full when all occupied", 64'(full), 64'd1);
    push(2'b00, 32'h70);
    chk(full === 1'b1, "R2 dropped while full", 64'(full), 64'd1);
    complete(5);
    chk(full === 1'b1, "R8 completion of waiting slot ignored", 64'(full), 64'd1);
    idle(); exp_none("R3 same queue held while full");
    push_cmp(2'b00, 32'h70, 0);
    chk(full === 1'b0, "R2 full falls, push dropped", 64'(full), 64'd0);
    push(2'b00, 32'h70);
    exp_issue("R5 older same queue first", 1, 32'h60);
    idle(); exp_issue("R4 other queue issues", 0, 32'h70);
    for (int k = 1; k < DEPTH; k++) begin
      complete(k);
      idle();
    end
    complete(0);
    idle(); exp_none("R2 dropped command never issues");
    idle();
    chk(full === 1'b0, "R2 table drained", 64'(full), 64'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R5 watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule